// File: doc/BRIEF.md
# Base-Offset-Index Address Generator

This block forms 64-bit effective addresses for memory reads, memory writes and address-only operations, which return the address as their result instead of touching memory. Each request names one base source. The source is either a pointer operand that arrives with the request, or one of six special base registers. The six registers hold the code region, the constant pool, static data, the stack frame, inbound memory-passed arguments and thread-local storage. A single three-input add combines the base, a sign-extended 32-bit immediate and an optional index operand shifted left by 0 to 4 bits. The sum wraps modulo 2^64.

Every 64-bit value carries a separate not-a-result (NaR) tag. A register that has no area behind it holds NaR. If the chosen base or an enabled index is NaR, the result is NaR and no memory request is raised. A loader or memory-mapped agent fills the special registers through a write port and inspects them through a combinational read port.

Requests enter on a valid/ready handshake. The result is registered and shows up in the cycle after acceptance. It carries the operation kind through unchanged.

Top module: `agu_top`

## Requirements
- R1: The result address is base + sign-extended 32-bit offset + scaled index, truncated to 64 bits, so it wraps with no trap.
- R2: When `req_idx_en` is 0, the inputs `req_idx`, `req_scale` and `req_idx_nar` have no effect on the address or on the NaR tag.
- R3: An enabled index is shifted left by `req_scale` bits for scale values 0 to 4. Scale values 5 to 7 behave as 4.
- R4: `req_base_sel` codes pick the base: 0 is the pointer operand, 1 code, 2 constant pool, 3 static data, 4 stack frame, 5 inbound arguments, 6 thread-local storage. Code 7 is reserved and yields NaR.
- R5: If the selected base is NaR, or the index is enabled and NaR, then `res_nar` is 1 and `res_mem_valid` is 0.
- R6: `res_kind` equals the accepted `req_kind` (0 load, 1 store, 2 address-only). `res_mem_valid` is 1 only for a valid, non-NaR load or store result, and never for an address-only result.
- R7: `req_ready` equals `!res_valid || res_ready`. An accepted request appears on the result outputs in the next cycle. While `res_valid` is 1 and `res_ready` is 0, the result outputs hold stable.
- R8: A register write to codes 1 to 6 sets that register's value and NaR tag. Writes to codes 0 and 7 change nothing. A read of the register being written in the same cycle returns the old value, and the new value is seen from the next cycle.
- R9: After reset, `res_valid` is 0 and all six special registers read as NaR with value 0. A read of code 0 or 7 returns NaR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_kind | input | 2 | 0 load, 1 store, 2 address-only |
| req_base_sel | input | 3 | Base source code |
| req_ptr | input | 64 | Pointer operand |
| req_ptr_nar | input | 1 | Pointer operand is NaR |
| req_offset | input | 32 | Signed immediate offset |
| req_idx_en | input | 1 | Index is used |
| req_idx | input | 64 | Index operand |
| req_idx_nar | input | 1 | Index operand is NaR |
| req_scale | input | 3 | Index left-shift amount |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken |
| res_kind | output | 2 | Operation kind of the result |
| res_addr | output | 64 | Effective address |
| res_nar | output | 1 | Result is NaR |
| res_mem_valid | output | 1 | Memory request is valid |
| bank_we | input | 1 | Special register write enable |
| bank_waddr | input | 3 | Register code written |
| bank_wdata | input | 64 | Value written |
| bank_wnar | input | 1 | NaR tag written |
| bank_raddr | input | 3 | Register code read |
| bank_rdata | output | 64 | Value read |
| bank_rnar | output | 1 | NaR tag read |

## Verification
The bench targets the following edges of the adder:
- A negative offset at -2^31. If the offset is zero-extended, the address comes out 4 GiB too high.
- A pointer near the top of the address space, which must wrap.
- An all-ones index. Mishandling its shift gives the wrong carry.
- Scale codes above 4. A design that shifts by the raw code moves the index too far.

A second group probes NaR handling:
- A NaR register, a NaR pointer and a NaR index must each poison the result.
- A NaR index with the index disabled must not poison it. A design that skips the enable check poisons it anyway.

A third group covers the register bank and the handshake:
- A read of a register in the same cycle it is written must return the old value. A design that forwards the write data fails this.
- Writes to the unused codes must change nothing.
- Under back-pressure, the registered result must hold. A design that overwrites it loses a request.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int ADDR_W = 64;
  localparam int OFF_W  = 32;
  localparam int SEL_W  = 3;
  localparam int SCL_W  = 3;
  localparam int MAX_SHIFT = 4;
  localparam int N_SPECIAL = 6;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_ADDR  = 2'd2,
    KIND_RSVD  = 2'd3
  } op_kind_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_PTR   = 3'd0,
    SEL_CODE  = 3'd1,
    SEL_CPOOL = 3'd2,
    SEL_DATA  = 3'd3,
    SEL_FRAME = 3'd4,
    SEL_ARGS  = 3'd5,
    SEL_TLS   = 3'd6,
    SEL_RSVD  = 3'd7
  } base_sel_e;

  typedef struct packed {
    logic [1:0]        kind;
    logic [ADDR_W-1:0] addr;
    logic              nar;
  } agu_res_t;
endpackage

// File: rtl/agu_base_bank.sv
module agu_base_bank
  import agu_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int SW    = SEL_W,
  parameter int NSLOT = N_SPECIAL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [AW-1:0] wdata,
  input  logic          wnar,
  input  logic [SW-1:0] sel_a,
  output logic [AW-1:0] val_a,
  output logic          nar_a,
  input  logic [SW-1:0] sel_b,
  output logic [AW-1:0] val_b,
  output logic          nar_b
);
  logic [AW-1:0] slot_val [NSLOT];
  logic          slot_nar [NSLOT];

  // Codes 1..NSLOT map to slots 0..NSLOT-1; everything else is unbacked.
  function automatic logic code_ok(input logic [SW-1:0] c);
    return (c >= SW'(1)) && (c <= SW'(NSLOT));
  endfunction

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic hit;
    assign hit = we && code_ok(waddr) && (waddr == SW'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_val[g] <= '0;
        slot_nar[g] <= 1'b1;
      end else if (hit) begin
        slot_val[g] <= wdata;
        slot_nar[g] <= wnar;
      end
    end
  end

  always_comb begin
    val_a = '0;
    nar_a = 1'b1;
    if (code_ok(sel_a)) begin
      val_a = slot_val[SW'(sel_a - SW'(1))];
      nar_a = slot_nar[SW'(sel_a - SW'(1))];
    end
  end

  always_comb begin
    val_b = '0;
    nar_b = 1'b1;
    if (code_ok(sel_b)) begin
      val_b = slot_val[SW'(sel_b - SW'(1))];
      nar_b = slot_nar[SW'(sel_b - SW'(1))];
    end
  end

  // R8: a write to a backed code is visible in the next cycle
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && code_ok(waddr)) |=>
      (slot_val[SW'($past(waddr) - SW'(1))] == $past(wdata)) &&
      (slot_nar[SW'($past(waddr) - SW'(1))] == $past(wnar)));

  // R8: with no write the bank contents hold
  assert_bank_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(slot_val[0]) && $stable(slot_nar[0]) &&
             $stable(slot_val[NSLOT-1]) && $stable(slot_nar[NSLOT-1])));
endmodule

// File: rtl/agu_adder3.sv
module agu_adder3
  import agu_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int OW   = OFF_W,
  parameter int CW   = SCL_W,
  parameter int MAXS = MAX_SHIFT
) (
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] offset,
  input  logic          idx_en,
  input  logic [AW-1:0] idx,
  input  logic [CW-1:0] scale,
  output logic [AW-1:0] sum
);
  logic [CW-1:0] shamt;
  logic [AW-1:0] idx_term;
  logic [AW-1:0] off_term;

  always_comb begin
    shamt    = (scale > CW'(MAXS)) ? CW'(MAXS) : scale;
    idx_term = idx_en ? (idx << shamt) : '0;
    off_term = {{(AW-OW){offset[OW-1]}}, offset};
    sum      = base + off_term + idx_term;
  end

  // R3: the shift never exceeds the supported maximum
  always_comb begin
    assert_shift_cap_R3: assert (shamt <= CW'(MAXS));
  end
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic [SEL_W-1:0]   req_base_sel,
  input  logic [ADDR_W-1:0]  req_ptr,
  input  logic               req_ptr_nar,
  input  logic [OFF_W-1:0]   req_offset,
  input  logic               req_idx_en,
  input  logic [ADDR_W-1:0]  req_idx,
  input  logic               req_idx_nar,
  input  logic [SCL_W-1:0]   req_scale,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [1:0]         res_kind,
  output logic [ADDR_W-1:0]  res_addr,
  output logic               res_nar,
  output logic               res_mem_valid,
  input  logic               bank_we,
  input  logic [SEL_W-1:0]   bank_waddr,
  input  logic [ADDR_W-1:0]  bank_wdata,
  input  logic               bank_wnar,
  input  logic [SEL_W-1:0]   bank_raddr,
  output logic [ADDR_W-1:0]  bank_rdata,
  output logic               bank_rnar
);
  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  logic [ADDR_W-1:0] spec_val;
  logic              spec_nar;

  agu_base_bank #(.AW(ADDR_W), .SW(SEL_W), .NSLOT(N_SPECIAL)) u_bank (
    .clk   (clk),
    .rst_n (rst_sn),
    .we    (bank_we),
    .waddr (bank_waddr),
    .wdata (bank_wdata),
    .wnar  (bank_wnar),
    .sel_a (req_base_sel),
    .val_a (spec_val),
    .nar_a (spec_nar),
    .sel_b (bank_raddr),
    .val_b (bank_rdata),
    .nar_b (bank_rnar)
  );

  logic [ADDR_W-1:0] base_val;
  logic              base_nar;
  logic [ADDR_W-1:0] ea;

  always_comb begin
    if (req_base_sel == SEL_PTR) begin
      base_val = req_ptr;
      base_nar = req_ptr_nar;
    end else begin
      base_val = spec_val;
      base_nar = spec_nar;
    end
  end

  agu_adder3 #(.AW(ADDR_W), .OW(OFF_W), .CW(SCL_W), .MAXS(MAX_SHIFT)) u_add (
    .base   (base_val),
    .offset (req_offset),
    .idx_en (req_idx_en),
    .idx    (req_idx),
    .scale  (req_scale),
    .sum    (ea)
  );

  // Next-state logic
  logic     accept;
  logic     valid_d;
  logic     res_en;
  agu_res_t res_d, res_q;

  always_comb begin
    req_ready  = !res_valid || res_ready;
    accept     = req_valid && req_ready;
    res_en     = accept;
    res_d.kind = req_kind;
    res_d.addr = ea;
    res_d.nar  = base_nar || (req_idx_en && req_idx_nar);
    if (accept)         valid_d = 1'b1;
    else if (res_ready) valid_d = 1'b0;
    else                valid_d = res_valid;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) res_valid <= 1'b0;
    else         res_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign res_kind      = res_q.kind;
  assign res_addr      = res_q.addr;
  assign res_nar       = res_q.nar;
  assign res_mem_valid = res_valid && !res_q.nar &&
                         (res_q.kind == KIND_LOAD || res_q.kind == KIND_STORE);

  // R7: an accepted request is presented in the next cycle
  assert_accept_next_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && req_ready) |=> res_valid);

  // R7: a stalled result holds
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_addr) && $stable(res_nar) && $stable(res_kind)));

  // R5: a NaR pointer base poisons the result
  assert_ptr_nar_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && req_ready && req_base_sel == SEL_PTR && req_ptr_nar) |=>
      (res_nar && !res_mem_valid));

  // R6: the operation kind passes through
  assert_kind_pass_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && req_ready) |=> (res_kind == $past(req_kind)));

  // R2: a disabled index cannot poison a valid pointer base
  assert_idx_off_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && req_ready && req_base_sel == SEL_PTR && !req_ptr_nar && !req_idx_en) |=>
      !res_nar);
endmodule

// File: tb/tb_agu_top.sv
module tb_agu_top;
  import agu_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n;
  logic               req_valid, req_ready;
  logic [1:0]         req_kind;
  logic [2:0]         req_base_sel;
  logic [63:0]        req_ptr;
  logic               req_ptr_nar;
  logic [31:0]        req_offset;
  logic               req_idx_en;
  logic [63:0]        req_idx;
  logic               req_idx_nar;
  logic [2:0]         req_scale;
  logic               res_valid, res_ready;
  logic [1:0]         res_kind;
  logic [63:0]        res_addr;
  logic               res_nar, res_mem_valid;
  logic               bank_we;
  logic [2:0]         bank_waddr;
  logic [63:0]        bank_wdata;
  logic               bank_wnar;
  logic [2:0]         bank_raddr;
  logic [63:0]        bank_rdata;
  logic               bank_rnar;

  agu_top dut (.*);

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  sel;
    logic [63:0] ptr;
    logic [31:0] off;
    logic        ien;
    logic [63:0] idx;
    logic [2:0]  scl;
    logic [63:0] exp_addr;
    logic        exp_nar;
  } vec_t;

  // Bank: code 0x1000, cpool 0x2000, data 0x3000, frame 0x4000, args NaR, tls 0x6000
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 64'h100, 32'h10, 1'b0, 64'hFFFF, 3'd3, 64'h110, 1'b0},               // R1 R2
    '{2'd1, 3'd0, 64'h100, 32'hFFFFFFFC, 1'b1, 64'd3, 3'd2, 64'h108, 1'b0},            // R1 R3
    '{2'd2, 3'd1, 64'h0, 32'h20, 1'b1, 64'd5, 3'd4, 64'h1070, 1'b0},                   // R4 R6
    '{2'd0, 3'd3, 64'h0, 32'h0, 1'b1, 64'd1, 3'd0, 64'h3001, 1'b0},                    // R4
    '{2'd0, 3'd5, 64'h0, 32'h0, 1'b0, 64'd0, 3'd0, 64'h0, 1'b1},                       // R5
    '{2'd1, 3'd0, 64'hFFFFFFFFFFFFFFF0, 32'h20, 1'b0, 64'd0, 3'd0, 64'h10, 1'b0},      // R1 wrap
    '{2'd0, 3'd6, 64'h0, 32'h7FFFFFFF, 1'b1, 64'd2, 3'd1, 64'h80006003, 1'b0},         // R4
    '{2'd1, 3'd0, 64'h10, 32'h80000000, 1'b0, 64'd0, 3'd0, 64'hFFFFFFFF80000010, 1'b0},// R1
    '{2'd0, 3'd4, 64'h0, 32'h8, 1'b1, 64'hFFFFFFFFFFFFFFFF, 3'd3, 64'h4000, 1'b0},     // R1 R4
    '{2'd2, 3'd0, 64'h0, 32'h0, 1'b1, 64'd1, 3'd7, 64'h10, 1'b0}                       // R3
  };

  task automatic bank_write(input logic [2:0] a, input logic [63:0] d, input logic nar);
    @(negedge clk);
    bank_we = 1'b1; bank_waddr = a; bank_wdata = d; bank_wnar = nar;
    @(negedge clk);
    bank_we = 1'b0;
  endtask

  // Drive at a falling edge; the result is registered at the next rising edge
  // and sampled at the falling edge after that.
  task automatic issue(input logic [1:0] k, input logic [2:0] s, input logic [63:0] p,
                       input logic pn, input logic [31:0] o, input logic ie,
                       input logic [63:0] ix, input logic ixn, input logic [2:0] sc);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_base_sel = s; req_ptr = p; req_ptr_nar = pn;
    req_offset = o; req_idx_en = ie; req_idx = ix; req_idx_nar = ixn; req_scale = sc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_base_sel = '0; req_ptr = '0;
    req_ptr_nar = 1'b0; req_offset = '0; req_idx_en = 1'b0; req_idx = '0;
    req_idx_nar = 1'b0; req_scale = '0; res_ready = 1'b1; bank_we = 1'b0;
    bank_waddr = '0; bank_wdata = '0; bank_wnar = 1'b0; bank_raddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    check(res_valid == 1'b0, "R9 res_valid", 64'(res_valid), 64'd0);
    check(req_ready == 1'b1, "R7 ready idle", 64'(req_ready), 64'd1);
    bank_raddr = 3'd3; #1;
    check(bank_rnar == 1'b1 && bank_rdata == 64'd0, "R9 bank NaR", bank_rdata, 64'd0);
    bank_raddr = 3'd7; #1;
    check(bank_rnar == 1'b1, "R9 reserved read NaR", 64'(bank_rnar), 64'd1);

    bank_write(3'd1, 64'h1000, 1'b0);
    bank_write(3'd2, 64'h2000, 1'b0);
    bank_write(3'd3, 64'h3000, 1'b0);
    bank_write(3'd4, 64'h4000, 1'b0);
    bank_write(3'd6, 64'h6000, 1'b0);
    bank_write(3'd0, 64'hDEAD, 1'b0);
    bank_write(3'd7, 64'hBEEF, 1'b0);

    // R8 writes to 0 and 7 ignored, others intact
    bank_raddr = 3'd0; #1;
    check(bank_rnar == 1'b1 && bank_rdata == 64'd0, "R8 code0 ignored", bank_rdata, 64'd0);
    bank_raddr = 3'd7; #1;
    check(bank_rnar == 1'b1 && bank_rdata == 64'd0, "R8 code7 ignored", bank_rdata, 64'd0);
    bank_raddr = 3'd5; #1;
    check(bank_rnar == 1'b1, "R8 args still NaR", 64'(bank_rnar), 64'd1);

    // R8 read during write returns old value
    @(negedge clk);
    bank_raddr = 3'd1; bank_we = 1'b1; bank_waddr = 3'd1; bank_wdata = 64'h9999; bank_wnar = 1'b0;
    #1;
    check(bank_rdata == 64'h1000, "R8 old value same cycle", bank_rdata, 64'h1000);
    @(negedge clk);
    bank_we = 1'b0; #1;
    check(bank_rdata == 64'h9999, "R8 new value next cycle", bank_rdata, 64'h9999);
    bank_write(3'd1, 64'h1000, 1'b0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].kind, VECS[i].sel, VECS[i].ptr, 1'b0, VECS[i].off, VECS[i].ien,
            VECS[i].idx, 1'b0, VECS[i].scl);
      check(res_valid, "R7 result next cycle", 64'(res_valid), 64'd1);
      check(res_nar == VECS[i].exp_nar, "R5 nar tag", 64'(res_nar), 64'(VECS[i].exp_nar));
      if (!VECS[i].exp_nar)
        check(res_addr == VECS[i].exp_addr, "R1 R3 R4 address", res_addr, VECS[i].exp_addr);
      check(res_kind == VECS[i].kind, "R6 kind", 64'(res_kind), 64'(VECS[i].kind));
      check(res_mem_valid == (!VECS[i].exp_nar && VECS[i].kind != 2'd2), "R6 mem valid",
            64'(res_mem_valid), 64'(!VECS[i].exp_nar && VECS[i].kind != 2'd2));
    end

    // R5 NaR pointer and NaR index
    issue(2'd0, 3'd0, 64'h40, 1'b1, 32'h0, 1'b0, 64'd0, 1'b0, 3'd0);
    check(res_nar && !res_mem_valid, "R5 ptr NaR", 64'(res_nar), 64'd1);
    issue(2'd1, 3'd0, 64'h40, 1'b0, 32'h0, 1'b1, 64'd1, 1'b1, 3'd0);
    check(res_nar && !res_mem_valid, "R5 idx NaR", 64'(res_nar), 64'd1);
    // R2 disabled NaR index ignored
    issue(2'd1, 3'd0, 64'h40, 1'b0, 32'h4, 1'b0, 64'hFFFF, 1'b1, 3'd4);
    check(!res_nar && res_addr == 64'h44 && res_mem_valid, "R2 idx disabled", res_addr, 64'h44);
    // R4 reserved base code
    issue(2'd0, 3'd7, 64'h40, 1'b0, 32'h0, 1'b0, 64'd0, 1'b0, 3'd0);
    check(res_nar, "R4 reserved sel NaR", 64'(res_nar), 64'd1);

    // R7 back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    req_valid = 1'b1; req_kind = 2'd0; req_base_sel = 3'd2; req_ptr_nar = 1'b0;
    req_offset = 32'h8; req_idx_en = 1'b0;
    @(negedge clk);
    check(res_valid && res_addr == 64'h2008, "R7 first accepted", res_addr, 64'h2008);
    check(req_ready == 1'b0, "R7 ready low stalled", 64'(req_ready), 64'd0);
    req_offset = 32'h10;
    @(negedge clk);
    check(res_addr == 64'h2008, "R7 held under stall", res_addr, 64'h2008);
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(res_valid && res_addr == 64'h2010, "R7 second after release", res_addr, 64'h2010);
    @(negedge clk);
    check(!res_valid, "R7 drains", 64'(res_valid), 64'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule